// File: doc/BRIEF.md
# Watchdog Timer with Power-Down Status

This block is a watchdog made of a base counter and a postscaler chained behind it. Together they count enabled clock ticks. When the selected period ends, the block raises a time-out. While the core runs, the time-out becomes a one-cycle reset request. While the core sleeps, it becomes a one-cycle wake request instead.

Two status flags record why the core last stopped or restarted:
- The time-out flag is cleared by a time-out.
- The power-down flag is cleared by a sleep that is actually taken.

Software clears the watchdog with a clear command and enters sleep with a sleep command. The power-on reset samples the postscaler select and holds it, so the period stays fixed until the next reset.

A sleep command issued while an enabled interrupt is already pending does nothing. A pending interrupt seen while asleep wakes the core immediately. No global interrupt enable takes part in that decision.

Top module: `wdt_pd_top`

## Requirements
- R1: On a cycle with `rst` high, the next clock edge sets the outputs to `to_flag`=1, `pd_flag`=1, `sleeping`=0, `reset_req`=0 and `wake_req`=0. The same edge zeroes the counter and postscaler and samples `ps_sel`.
- R2: The count advances on a cycle with `tick` high only when `cfg_en` or `sw_en` is 1. With both enables at 0, no time-out ever occurs and the count holds its value.
- R3: A time-out occurs on the 2^(BASE_W+sel)-th enabled tick after the last clear, where sel is the `ps_sel` value sampled at reset. Changes on `ps_sel` after reset have no effect on the period.
- R4: A clear command (`clrwdt`) while awake zeroes the count. At the next edge it sets `to_flag`=1 and `pd_flag`=1.
- R5: A sleep command with `irq_pending`=0 while awake zeroes the count. At the next edge it sets `to_flag`=1, `pd_flag`=0 and `sleeping`=1. The count keeps advancing while asleep.
- R6: A sleep command while `irq_pending`=1 is a no-op. `sleeping` stays 0, both flags are unchanged, and the count is not zeroed, so the next time-out keeps its original schedule.
- R7: A time-out while awake gives `reset_req`=1 for exactly one cycle, starting the edge after the time-out tick. It also clears `to_flag` and restarts the count from zero.
- R8: A time-out while asleep gives `wake_req`=1 for one cycle and no `reset_req`. It clears `to_flag` and `sleeping`, and leaves `pd_flag` at 0.
- R9: `irq_pending` high while asleep gives `wake_req`=1 for one cycle and clears `sleeping`. The flags are unchanged.
- R10: While asleep, `clrwdt` and `sleep_req` are ignored. The count, the flags and the time-out schedule are unaffected.
- R11: When commands coincide in one cycle:
  - A taken sleep wins over `clrwdt`.
  - A clear or a taken sleep on the tick that would end the period suppresses the time-out.
  - `reset_req` and `wake_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Watchdog count tick qualifier |
| cfg_en | input | 1 | Fixed enable from configuration |
| sw_en | input | 1 | Software enable, effective when `cfg_en` is 0 |
| ps_sel | input | SEL_W | Postscaler tap select, sampled at reset |
| clrwdt | input | 1 | Clear-watchdog command pulse |
| sleep_req | input | 1 | Sleep entry command pulse |
| irq_pending | input | 1 | An enabled interrupt is pending |
| reset_req | output | 1 | One-cycle core reset request on time-out while awake |
| wake_req | output | 1 | One-cycle wake request from sleep |
| sleeping | output | 1 | Core is in sleep |
| to_flag | output | 1 | Time-out status flag, 0 after a time-out |
| pd_flag | output | 1 | Power-down status flag, 0 after a taken sleep |

## Verification
The hardest case to reach is a command that lands on exactly the tick that would end the period, since that tick depends on the sampled select and on the gaps in `tick`. The bench carries its own count of enabled ticks. It issues `clrwdt` or `sleep_req` on the cycle that count predicts as the last one of the period, and expects no request to follow. The same count lets the bench confirm that a sleep refused because of a pending interrupt leaves the original time-out cycle in place. It also confirms that commands issued while asleep leave the schedule untouched.

// File: rtl/wdt_pd_pkg.sv
package wdt_pd_pkg;
  typedef struct packed {
    logic to;
    logic pd;
  } wdt_flags_t;

  localparam wdt_flags_t FLAGS_POR = '{to: 1'b1, pd: 1'b1};
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int BASE_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel_in,
  output logic             tout
);
  localparam int NTAPS = 1 << SEL_W;
  localparam int CNT_W = BASE_W + NTAPS - 1;

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel_q;
  logic [NTAPS-1:0] tap;
  logic             adv;

  // Tap i is complete when the low BASE_W+i bits are all ones.
  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    localparam int LOW = BASE_W + i;
    assign tap[i] = &cnt[LOW-1:0];
  end

  assign adv  = run & tick;
  assign tout = adv & ~clr & tap[sel_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sel_q <= sel_in;
    end else if (clr || tout) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: without an enabled tick or a clear, the count holds.
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt));

  // R3: the sampled select never changes outside reset.
  p_sel_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(sel_q));

  // R7: a time-out restarts the count from zero.
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    tout |=> (cnt == '0));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clrwdt,
  input  logic sleep_req,
  input  logic irq_pending,
  input  logic tout,
  output logic clr,
  output logic to_flag,
  output logic pd_flag,
  output logic sleeping,
  output logic reset_req,
  output logic wake_req
);
  wdt_flags_t flags;
  logic       sl;
  logic       sleep_take;
  logic       clr_take;
  logic       wake_now;

  assign sleep_take = ~sl & sleep_req & ~irq_pending;
  assign clr_take   = ~sl & clrwdt & ~sleep_take;
  assign clr        = sleep_take | clr_take;
  assign wake_now   = sl & (tout | irq_pending);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= FLAGS_POR;
      sl        <= 1'b0;
      reset_req <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      reset_req <= tout & ~sl;
      wake_req  <= wake_now;

      if (tout) begin
        flags.to <= 1'b0;
      end else if (clr) begin
        flags.to <= 1'b1;
      end

      if (sleep_take) begin
        flags.pd <= 1'b0;
      end else if (clr_take) begin
        flags.pd <= 1'b1;
      end

      if (sleep_take) begin
        sl <= 1'b1;
      end else if (wake_now) begin
        sl <= 1'b0;
      end
    end
  end

  assign to_flag  = flags.to;
  assign pd_flag  = flags.pd;
  assign sleeping = sl;

  // R1: power-on leaves both flags set and the core awake.
  p_por_state_r1: assert property (@(posedge clk)
    rst |=> (to_flag && pd_flag && !sleeping && !reset_req && !wake_req));

  // R4: a clear while awake, with no taken sleep, sets both flags.
  p_clear_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && clrwdt && !(sleep_req && !irq_pending)) |=> (to_flag && pd_flag));

  // R5: a taken sleep enters sleep with PD clear and TO set.
  p_sleep_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && sleep_req && !irq_pending) |=> (sleeping && !pd_flag && to_flag));

  // R6: a refused sleep leaves the status flags unchanged.
  p_sleep_noop_r6: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && sleep_req && irq_pending && !clrwdt && !tout)
      |=> ($stable(to_flag) && $stable(pd_flag) && !sleeping));

  // R9: a pending interrupt while asleep wakes the core.
  p_irq_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (sleeping && irq_pending) |=> (wake_req && !sleeping));

  // R11: the two requests are never raised together.
  p_req_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reset_req, wake_req}));
endmodule

// File: rtl/wdt_pd_top.sv
module wdt_pd_top #(
  parameter int BASE_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_en,
  input  logic             sw_en,
  input  logic [SEL_W-1:0] ps_sel,
  input  logic             clrwdt,
  input  logic             sleep_req,
  input  logic             irq_pending,
  output logic             reset_req,
  output logic             wake_req,
  output logic             sleeping,
  output logic             to_flag,
  output logic             pd_flag
);
  logic run;
  logic clr;
  logic tout;

  assign run = cfg_en | sw_en;

  wdt_count #(
    .BASE_W(BASE_W),
    .SEL_W (SEL_W)
  ) u_count (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .run   (run),
    .clr   (clr),
    .sel_in(ps_sel),
    .tout  (tout)
  );

  wdt_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .clrwdt     (clrwdt),
    .sleep_req  (sleep_req),
    .irq_pending(irq_pending),
    .tout       (tout),
    .clr        (clr),
    .to_flag    (to_flag),
    .pd_flag    (pd_flag),
    .sleeping   (sleeping),
    .reset_req  (reset_req),
    .wake_req   (wake_req)
  );

  // R8: a wake request is only ever raised out of sleep.
  p_wake_from_sleep_r8: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(sleeping));

  // R10: while asleep, commands never raise PD.
  p_sleep_ignores_r10: assert property (@(posedge clk) disable iff (rst)
    (sleeping && !wake_req) |-> !pd_flag);
endmodule

// File: tb/tb_wdt_pd_top.sv
module tb_wdt_pd_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_W     = 4;
  localparam int SEL_W      = 3;
  localparam int CNT_MOD    = 1 << (BASE_W + (1 << SEL_W) - 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic             cfg_en = 1'b0;
  logic             sw_en = 1'b0;
  logic [SEL_W-1:0] ps_sel = '0;
  logic             clrwdt = 1'b0;
  logic             sleep_req = 1'b0;
  logic             irq_pending = 1'b0;
  logic             reset_req, wake_req, sleeping, to_flag, pd_flag;

  wdt_pd_top #(.BASE_W(BASE_W), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .cfg_en(cfg_en), .sw_en(sw_en),
    .ps_sel(ps_sel), .clrwdt(clrwdt), .sleep_req(sleep_req),
    .irq_pending(irq_pending), .reset_req(reset_req), .wake_req(wake_req),
    .sleeping(sleeping), .to_flag(to_flag), .pd_flag(pd_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  // Behavioural reference state.
  int m_ticks = 0;
  int m_sel   = 0;
  bit m_to = 1, m_pd = 1, m_sl = 0, m_rr = 0, m_wk = 0;
  int rr_seen = 0, wk_seen = 0;
  bit rand_tick = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int period();
    return 1 << (BASE_W + m_sel);
  endfunction

  function automatic bit ends_now();
    return ((m_ticks + 1) % period()) == 0;
  endfunction

  task automatic model_edge();
    bit run, sleep_take, clr_take, clear, tout, wake;
    if (rst) begin
      m_ticks = 0; m_sel = int'(ps_sel);
      m_to = 1; m_pd = 1; m_sl = 0; m_rr = 0; m_wk = 0;
    end else begin
      run        = cfg_en || sw_en;
      sleep_take = !m_sl && sleep_req && !irq_pending;
      clr_take   = !m_sl && clrwdt && !sleep_take;
      clear      = sleep_take || clr_take;
      tout       = run && tick && !clear && ends_now();
      wake       = m_sl && (tout || irq_pending);
      m_rr = tout && !m_sl;
      m_wk = wake;
      if (clear || tout) m_ticks = 0;
      else if (run && tick) m_ticks = (m_ticks + 1) % CNT_MOD;
      if (tout) m_to = 0; else if (clear) m_to = 1;
      if (sleep_take) m_pd = 0; else if (clr_take) m_pd = 1;
      if (sleep_take) m_sl = 1; else if (wake) m_sl = 0;
    end
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int act, exp;
    act = {reset_req, wake_req, sleeping, to_flag, pd_flag};
    exp = {m_rr, m_wk, m_sl, m_to, m_pd};
    check(act == exp, "outputs {rr,wk,sl,to,pd}", act, exp);
    if (reset_req) rr_seen++;
    if (wake_req)  wk_seen++;
  endtask

  // Inputs are stable from the previous falling edge through this rising edge.
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    clrwdt = 0; sleep_req = 0;
    if (rand_tick) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick = lfsr[0] | lfsr[3];
    end
  endtask

  task automatic run_n(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic do_reset(input int sel);
    rst = 1; ps_sel = SEL_W'(sel);
    run_n(2);
    rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R1"; do_reset(0);
    check(to_flag && pd_flag && !sleeping, "R1 reset flags", {to_flag, pd_flag, sleeping}, 3'b110);

    cur_req = "R2"; tick = 1; rr_seen = 0; run_n(40);
    check(rr_seen == 0, "R2 disabled no time-out", rr_seen, 0);

    cur_req = "R7"; sw_en = 1; rr_seen = 0; run_n(20);
    check(rr_seen == 1, "R7 one reset pulse", rr_seen, 1);
    check(!to_flag, "R7 TO cleared", to_flag, 0);

    cur_req = "R3"; cfg_en = 1; sw_en = 0; do_reset(2); ps_sel = 0; rr_seen = 0;
    run_n(63);
    check(rr_seen == 0, "R3 no early time-out", rr_seen, 0);
    run_n(2);
    check(rr_seen == 1, "R3 time-out at 64", rr_seen, 1);
    rand_tick = 1; run_n(200);

    cur_req = "R4"; run_n(10); clrwdt = 1; run_n(1);
    check(to_flag && pd_flag, "R4 flags set", {to_flag, pd_flag}, 2'b11);
    run_n(40);

    cur_req = "R5"; sleep_req = 1; run_n(1);
    check(sleeping && !pd_flag && to_flag, "R5 sleep entry", {sleeping, pd_flag, to_flag}, 3'b101);
    cur_req = "R8"; wk_seen = 0; rr_seen = 0;
    while (m_sl) cyc();
    check(wk_seen == 1 && rr_seen == 0, "R8 wake not reset", wk_seen * 10 + rr_seen, 10);
    check(!to_flag && !pd_flag, "R8 flags", {to_flag, pd_flag}, 0);

    cur_req = "R6"; run_n(7); irq_pending = 1; sleep_req = 1; run_n(1);
    irq_pending = 0;
    check(!sleeping, "R6 sleep refused", sleeping, 0);
    run_n(120);

    cur_req = "R9"; sleep_req = 1; run_n(4); irq_pending = 1; wk_seen = 0; run_n(1);
    irq_pending = 0;
    check(wk_seen == 1 && !sleeping, "R9 irq wake", wk_seen, 1);
    run_n(30);

    cur_req = "R10"; sleep_req = 1; run_n(3);
    clrwdt = 1; run_n(2); sleep_req = 1; run_n(2); clrwdt = 1; run_n(1);
    check(!pd_flag && sleeping, "R10 commands ignored", {pd_flag, sleeping}, 2'b01);
    while (m_sl) cyc();

    cur_req = "R11"; sleep_req = 1; clrwdt = 1; run_n(1);
    check(!pd_flag && sleeping, "R11 sleep beats clear", {pd_flag, sleeping}, 2'b01);
    irq_pending = 1; run_n(1); irq_pending = 0; run_n(5);
    rand_tick = 0; tick = 1;
    while (!ends_now()) cyc();
    clrwdt = 1; rr_seen = 0; run_n(2);
    check(rr_seen == 0, "R11 clear on final tick", rr_seen, 0);
    while (!ends_now()) cyc();
    sleep_req = 1; rr_seen = 0; wk_seen = 0; run_n(2);
    check(rr_seen == 0 && wk_seen == 0 && sleeping, "R11 sleep on final tick", rr_seen + wk_seen, 0);
    irq_pending = 1; run_n(1); irq_pending = 0;

    cur_req = "R3"; do_reset(7); ps_sel = 3'd1; rand_tick = 1; rr_seen = 0;
    run_n(5000);
    check(rr_seen >= 1, "R3 longest period", rr_seen, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule